// File: doc/BRIEF.md
# Event Pulse and Wakeup Aggregator

This block gathers per-line activity from two banks of request lines and produces three outputs. The first is a single CPU event pulse. The second is an asynchronous system wakeup request. The third is a synchronous CPU wakeup.

The configurable bank supplies two signals per line: a one-cycle trigger (an active edge already detected upstream) and a pending flag. The direct bank supplies level requests held by the requesting peripherals. Each line has its own event mask and interrupt mask.

- **Events.** A line's event request is gated only by its event mask. A direct line raises an event request only on the rising edge of its level. All masked event requests are ORed into one pulse generator. That generator emits one clock-wide pulse for each rise of the combined request.
- **Wakeup.** A line requests wakeup while it is active and either of its masks is set. For direct lines, the interrupt mask serves only as a wakeup enable.
- **System wakeup.** All wakeup requests and event requests are ORed, with no clock in the path, to form the system wakeup. It can therefore restart a stopped clock.
- **CPU wakeup.** The system wakeup passes through a two-flop synchronizer. It is then qualified by the clock-running input to give the CPU wakeup.

Top module: `evt_wake_agg`

## Requirements
- R1: One clock edge after an enabled event request rises, `evt_pulse_o` is high for exactly one cycle. An enabled event request is a configurable trigger whose event mask bit is 1, or a direct line rise whose event mask bit is 1.
- R2: Event requests from all lines are ORed before pulse generation. Requests on different lines in back-to-back cycles give a single pulse. A second pulse requires the combined request to be low for at least one cycle.
- R3: A direct line produces an event only on the 0-to-1 transition of its level. Holding the level high gives no further pulse, and the falling edge gives none.
- R4: The interrupt mask has no effect on event generation. A line with only its interrupt mask set never produces `evt_pulse_o`. A configurable pending flag alone raises no event.
- R5: `sys_wake_o` is high while a configurable line has its trigger or pending flag set and its interrupt mask bit or event mask bit is 1.
- R6: `sys_wake_o` is high for as long as a direct line holds its request level high with its interrupt mask bit or event mask bit set.
- R7: A line whose interrupt and event mask bits are both 0 has no effect on `evt_pulse_o`, `sys_wake_o` or `cpu_wake_o`.
- R8: `sys_wake_o` follows its inputs combinationally with no clock edge in the path, including while reset is asserted.
- R9: `cpu_wake_o` equals `sys_wake_o` delayed by two rising clock edges, ANDed with the current value of `clk_run_i`.
- R10: During reset, `evt_pulse_o` and `cpu_wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_trig_i | input | N_CFG | Configurable-line triggers, one cycle per detected edge |
| cfg_pend_i | input | N_CFG | Configurable-line pending flags |
| cfg_imask_i | input | N_CFG | Configurable-line interrupt masks (1 = enabled) |
| cfg_emask_i | input | N_CFG | Configurable-line event masks (1 = enabled) |
| dir_req_i | input | N_DIR | Direct-line request levels |
| dir_imask_i | input | N_DIR | Direct-line interrupt masks, used as wakeup enables |
| dir_emask_i | input | N_DIR | Direct-line event masks |
| clk_run_i | input | 1 | High when the bus clock is running |
| evt_pulse_o | output | 1 | One-cycle CPU event pulse |
| sys_wake_o | output | 1 | Asynchronous system wakeup request |
| cpu_wake_o | output | 1 | Synchronized CPU wakeup |

## Verification
The assertions assume a few things about the inputs:
- Direct request levels and configurable triggers are synchronous to `clk_i`.
- A configurable trigger lasts one cycle.
- Masks change only between clock edges.

The bench drives every input on the falling edge, so each value is stable across the next rising edge. It pulses triggers for exactly one cycle, and it holds direct levels for several cycles before releasing them. It sweeps every line through all four mask combinations. Each stimulus is separated by idle cycles, so the edge detectors and the synchronizer settle before the next case.

// File: rtl/evt_wake_pkg.sv
`timescale 1ns/1ps
package evt_wake_pkg;
  localparam int unsigned N_CFG_DEF = 18;
  localparam int unsigned N_DIR_DEF = 16;
  localparam int unsigned SYNC_DEF  = 2;

  typedef struct packed {
    logic evt;
    logic wake;
  } bank_sum_t;
endpackage

// File: rtl/cfg_line_bank.sv
`timescale 1ns/1ps
module cfg_line_bank
  import evt_wake_pkg::*;
#(
  parameter int unsigned N = N_CFG_DEF
) (
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] imask_i,
  input  logic [N-1:0] emask_i,
  output bank_sum_t    sum_o
);
  logic [N-1:0] evt_l;
  logic [N-1:0] wake_l;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign evt_l[g]  = trig_i[g] & emask_i[g];
    assign wake_l[g] = (trig_i[g] | pend_i[g]) & (imask_i[g] | emask_i[g]);
  end

  assign sum_o.evt  = |evt_l;
  assign sum_o.wake = |wake_l;
endmodule

// File: rtl/dir_line_bank.sv
`timescale 1ns/1ps
module dir_line_bank
  import evt_wake_pkg::*;
#(
  parameter int unsigned N = N_DIR_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] imask_i,
  input  logic [N-1:0] emask_i,
  output bank_sum_t    sum_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] evt_l;
  logic [N-1:0] wake_l;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q[g] <= 1'b0;
      else         req_q[g] <= req_i[g];
    end
    // rising edge only; pending state is the held level itself
    assign evt_l[g]  = req_i[g] & ~req_q[g] & emask_i[g];
    assign wake_l[g] = req_i[g] & (imask_i[g] | emask_i[g]);
  end

  assign sum_o.evt  = |evt_l;
  assign sum_o.wake = |wake_l;

  // R3
  dir_evt_needs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o.evt |-> (|(req_i & ~req_q)));
endmodule

// File: rtl/evt_pulse_gen.sv
`timescale 1ns/1ps
module evt_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pulse_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      req_q   <= req_i;
      pulse_o <= req_i & ~req_q;
    end
  end

  // R1
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  // R2
  pulse_from_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(req_i));
endmodule

// File: rtl/wake_sync.sv
`timescale 1ns/1ps
module wake_sync
  import evt_wake_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_wake_i,
  input  logic clk_run_i,
  output logic cpu_wake_o
);
  logic [STAGES-1:0] sync_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sys_wake_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign cpu_wake_o = sync_q[STAGES-1] & clk_run_i;

  if (STAGES == 2) begin : g_chk
    // R9
    cpu_wake_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_wake_o |-> $past(sys_wake_i, 2));
  end
endmodule

// File: rtl/evt_wake_agg.sv
`timescale 1ns/1ps
module evt_wake_agg
  import evt_wake_pkg::*;
#(
  parameter int unsigned N_CFG = N_CFG_DEF,
  parameter int unsigned N_DIR = N_DIR_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CFG-1:0] cfg_trig_i,
  input  logic [N_CFG-1:0] cfg_pend_i,
  input  logic [N_CFG-1:0] cfg_imask_i,
  input  logic [N_CFG-1:0] cfg_emask_i,
  input  logic [N_DIR-1:0] dir_req_i,
  input  logic [N_DIR-1:0] dir_imask_i,
  input  logic [N_DIR-1:0] dir_emask_i,
  input  logic             clk_run_i,
  output logic             evt_pulse_o,
  output logic             sys_wake_o,
  output logic             cpu_wake_o
);
  bank_sum_t cfg_sum;
  bank_sum_t dir_sum;
  logic      evt_req;

  cfg_line_bank #(.N(N_CFG)) u_cfg (
    .trig_i (cfg_trig_i),
    .pend_i (cfg_pend_i),
    .imask_i(cfg_imask_i),
    .emask_i(cfg_emask_i),
    .sum_o  (cfg_sum)
  );

  dir_line_bank #(.N(N_DIR)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (dir_req_i),
    .imask_i(dir_imask_i),
    .emask_i(dir_emask_i),
    .sum_o  (dir_sum)
  );

  assign evt_req = cfg_sum.evt | dir_sum.evt;

  evt_pulse_gen u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (evt_req),
    .pulse_o(evt_pulse_o)
  );

  // no clock in this path
  assign sys_wake_o = cfg_sum.wake | dir_sum.wake | evt_req;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_wake_i(sys_wake_o),
    .clk_run_i (clk_run_i),
    .cpu_wake_o(cpu_wake_o)
  );

  // R7
  pulse_needs_emask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_pulse_o |-> $past((|cfg_emask_i) | (|dir_emask_i)));
  // R6
  dir_hold_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(dir_req_i & (dir_imask_i | dir_emask_i))) |-> sys_wake_o);
endmodule

// File: tb/evt_wake_agg_bench.sv
`timescale 1ns/1ps
module evt_wake_agg_bench;
  localparam int NC = 18;
  localparam int ND = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni;
  logic [NC-1:0] cfg_trig, cfg_pend, cfg_imask, cfg_emask;
  logic [ND-1:0] dir_req, dir_imask, dir_emask;
  logic          clk_run;
  logic          evt_pulse, sys_wake, cpu_wake;

  evt_wake_agg u_evt_wake_agg (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cfg_trig_i (cfg_trig),
    .cfg_pend_i (cfg_pend),
    .cfg_imask_i(cfg_imask),
    .cfg_emask_i(cfg_emask),
    .dir_req_i  (dir_req),
    .dir_imask_i(dir_imask),
    .dir_emask_i(dir_emask),
    .clk_run_i  (clk_run),
    .evt_pulse_o(evt_pulse),
    .sys_wake_o (sys_wake),
    .cpu_wake_o (cpu_wake)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    cfg_trig = '0; cfg_pend = '0; cfg_imask = '0; cfg_emask = '0;
    dir_req = '0; dir_imask = '0; dir_emask = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    clear_all();
    clk_run = 1'b1;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    // R10
    chk("R10 evt_pulse in reset", evt_pulse, 1'b0);
    chk("R10 cpu_wake in reset", cpu_wake, 1'b0);
    chk("R8 sys_wake idle in reset", sys_wake, 1'b0);
    // R8: combinational even in reset
    cfg_pend[0] = 1'b1; cfg_imask[0] = 1'b1;
    #1 chk("R8 sys_wake async in reset", sys_wake, 1'b1);
    clear_all();
    #1 chk("R8 sys_wake drops in reset", sys_wake, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // configurable sweep: every line, every mask combination
    for (int i = 0; i < NC; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic im, em;
        im = m[0]; em = m[1];
        clear_all();
        cfg_imask[i] = im; cfg_emask[i] = em;
        cfg_trig[i] = 1'b1;
        #1 chk("R5 trig wake", sys_wake, im | em);
        @(negedge clk);
        cfg_trig = '0;
        chk("R1 R4 R7 cfg pulse", evt_pulse, em);
        #1 chk("R5 wake after trig", sys_wake, 1'b0);
        @(negedge clk);
        chk("R1 pulse width", evt_pulse, 1'b0);
        chk("R9 R7 cpu wake", cpu_wake, im | em);
        cfg_pend[i] = 1'b1;
        #1 chk("R5 pend wake", sys_wake, im | em);
        repeat (2) @(negedge clk);
        chk("R4 pend no event", evt_pulse, 1'b0);
        chk("R5 pend wake held", sys_wake, im | em);
        cfg_pend = '0;
        repeat (3) @(negedge clk);
      end
    end

    // direct sweep
    for (int j = 0; j < ND; j++) begin
      for (int m = 0; m < 4; m++) begin
        logic im, em;
        im = m[0]; em = m[1];
        clear_all();
        dir_imask[j] = im; dir_emask[j] = em;
        dir_req[j] = 1'b1;
        #1 chk("R6 dir wake", sys_wake, im | em);
        @(negedge clk);
        chk("R3 R4 R7 dir pulse", evt_pulse, em);
        @(negedge clk);
        chk("R3 held no pulse", evt_pulse, 1'b0);
        chk("R6 dir wake held", sys_wake, im | em);
        @(negedge clk);
        chk("R3 held no pulse 2", evt_pulse, 1'b0);
        dir_req = '0;
        #1 chk("R6 dir wake released", sys_wake, 1'b0);
        @(negedge clk);
        chk("R3 fall no pulse", evt_pulse, 1'b0);
        repeat (2) @(negedge clk);
      end
    end

    // R2 back-to-back requests on different lines merge
    clear_all();
    cfg_emask = '1; dir_emask = '1;
    cfg_trig[0] = 1'b1;
    @(negedge clk);
    cfg_trig = '0; cfg_trig[1] = 1'b1;
    chk("R2 first pulse", evt_pulse, 1'b1);
    @(negedge clk);
    cfg_trig = '0;
    chk("R2 merged no second pulse", evt_pulse, 1'b0);
    repeat (3) @(negedge clk);
    // separated by one idle cycle: two pulses
    cfg_trig[0] = 1'b1;
    @(negedge clk);
    cfg_trig = '0;
    chk("R2 gap pulse a", evt_pulse, 1'b1);
    @(negedge clk);
    cfg_trig[1] = 1'b1;
    chk("R2 gap low", evt_pulse, 1'b0);
    @(negedge clk);
    cfg_trig = '0;
    chk("R2 gap pulse b", evt_pulse, 1'b1);
    repeat (3) @(negedge clk);
    // configurable then direct rise merge
    cfg_trig[2] = 1'b1;
    @(negedge clk);
    cfg_trig = '0; dir_req[2] = 1'b1;
    chk("R2 mixed first", evt_pulse, 1'b1);
    @(negedge clk);
    chk("R2 mixed merged", evt_pulse, 1'b0);
    dir_req = '0;
    repeat (3) @(negedge clk);

    // R9 clock-running qualification and two-edge delay
    clear_all();
    clk_run = 1'b0;
    cfg_imask[3] = 1'b1; cfg_pend[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 blocked while clock off", cpu_wake, 1'b0);
    chk("R5 sys wake with clock off", sys_wake, 1'b1);
    clk_run = 1'b1;
    #1 chk("R9 follows clk_run", cpu_wake, 1'b1);
    cfg_pend = '0;
    #1 chk("R9 no immediate drop", cpu_wake, 1'b1);
    @(negedge clk);
    chk("R9 one edge later", cpu_wake, 1'b1);
    @(negedge clk);
    chk("R9 two edges later", cpu_wake, 1'b0);

    // R7 everything active, all masks off
    clear_all();
    cfg_trig = '1; cfg_pend = '1; dir_req = '1;
    #1 chk("R7 sys wake masked", sys_wake, 1'b0);
    @(negedge clk);
    cfg_trig = '0;
    chk("R7 no pulse masked", evt_pulse, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7 no cpu wake masked", cpu_wake, 1'b0);
    clear_all();
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule